// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Wakeup Filter

This block receives asynchronous serial characters from a 16x oversampled RX line and decides, per character, whether the character may touch the receive status. It confirms the start bit at mid-bit and samples every later bit at its centre. The character is eight data bits, least significant first, then one stop bit. When the multidrop format is selected, a ninth "address" bit sits between the data bits and the stop bit.

In a shared-bus system several processors listen on one line. Each listener can arm a wakeup filter. With the filter armed, only characters whose address bit is 1 reach the status: data-ready, framing error and overrun. Other characters vanish without a trace. With the filter disarmed, or with the multidrop format off, every character is handled.

Software sees an 8-bit control register and a data port:

| Bit | Field |
|-----|-------|
| 7 | wakeup filter enable |
| 6 | receiver enable |
| 5 | transmitter enable (stored only) |
| 4 | request-to-send level, driven on `rts_o` |
| 3 | read: address bit of the last accepted character; write 0: clear the error flags |
| 2:0 | mode (stored only) |

Reading the data port clears the data-ready flag.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset the control register reads 0x10, `rts_o` is 1, and `rx_full`, `err_ovr` and `err_frm` are 0.
- R2: With the multidrop format off, a character of start, eight data bits (LSB first) and stop is delivered on `rx_data` and sets `rx_full` by the end of its stop bit.
- R3: With the multidrop format on and control bit 7 set, a character whose address bit is 0 changes neither `rx_full`, `err_frm`, `err_ovr` nor `rx_data`, even with a bad stop bit.
- R4: With the multidrop format on and control bit 7 set, a character whose address bit is 1 is accepted, and control bit 3 then reads 1.
- R5: With the multidrop format on and control bit 7 clear, every character is accepted, and control bit 3 reads the received address bit.
- R6: With the multidrop format off, control bit 7 has no effect and no ninth bit is expected.
- R7: An accepted character whose line is low at the stop-bit centre sets `err_frm`.
- R8: An accepted character that completes while `rx_full` is 1 sets `err_ovr` and leaves `rx_data` unchanged.
- R9: A pulse on `data_rd` clears `rx_full` on the next clock edge.
- R10: A control write with bit 3 = 0 clears `err_ovr` and `err_frm`; a write with bit 3 = 1 leaves them unchanged.
- R11: With control bit 6 clear, the receiver stays idle and a character on the line changes no status.
- R12: A low pulse shorter than half a bit period is rejected as a false start and produces no character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | 16x oversampling enable |
| rx_i | input | 1 | Serial receive line, idle high |
| mp_fmt | input | 1 | Multidrop format select (adds the address bit) |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| data_rd | input | 1 | Data port read strobe |
| ctrl_rdata | output | 8 | Control register read value |
| rx_data | output | 8 | Last accepted data byte |
| rx_full | output | 1 | Data-ready flag |
| err_ovr | output | 1 | Overrun error flag |
| err_frm | output | 1 | Framing error flag |
| rts_o | output | 1 | Request-to-send level from control bit 4 |

## Verification
The bench sends characters that are filtered out while carrying a bad stop bit. A design that applied the filter to data-ready only would then raise a framing error that should never appear. It also runs the same settings with the multidrop format off, where a design that looked at the filter bit anyway would drop characters or wait for a ninth bit that never comes. An overrun test checks that the older byte survives; a design that overwrote it would show the second byte. A short low glitch and a disabled receiver must both leave every flag at zero; a receiver that never re-checks the start bit at mid-bit would decode a character out of the glitch.

// File: rtl/mpr_pkg.sv
// Shared types for the multidrop receiver.
// Assumes: a character holds at most one address bit.
package mpr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_ADDR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic       wake;
        logic       rx_en;
        logic       tx_en;
        logic       rts;
        logic [2:0] mode;
    } ctrl_t;
endpackage

// File: rtl/mpr_bit_engine.sv
// Bit-level receiver. It synchronises the RX line, confirms the start bit
// at mid-bit and samples each later bit at its centre. At the stop-bit
// centre it pulses done_o for one cycle.
// Assumes: os_tick runs at OS times the bit rate, and data arrives LSB first.
module mpr_bit_engine #(
    parameter int DATA_W = 8,
    parameter int OS     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              enable,
    input  logic              mp_fmt,
    input  logic              rx_i,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              addr_o,
    output logic              stop_ok_o,
    output logic              busy_o
);
    import mpr_pkg::*;

    localparam int CW   = $clog2(OS);
    localparam int IW   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int HALF = OS / 2 - 1;
    localparam int LAST = OS - 1;

    rx_state_e         state_q;
    logic [CW-1:0]     cnt_q;
    logic [IW-1:0]     idx_q;
    logic [DATA_W-1:0] shift_q;
    logic [1:0]        sync_q;
    logic              rx_s;

    assign rx_s   = sync_q[1];
    assign data_o = shift_q;
    assign busy_o = (state_q != ST_IDLE);

    // Two-flop synchroniser on the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_i};
    end

    // Character framing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            idx_q     <= '0;
            shift_q   <= '0;
            addr_o    <= 1'b0;
            stop_ok_o <= 1'b1;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (!enable) begin
                state_q <= ST_IDLE;
            end else if (os_tick) begin
                case (state_q)
                    ST_IDLE: begin
                        cnt_q <= '0;
                        idx_q <= '0;
                        if (!rx_s) state_q <= ST_START;
                    end
                    ST_START: begin
                        if (cnt_q == CW'(HALF)) begin
                            cnt_q   <= '0;
                            state_q <= rx_s ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CW'(LAST)) begin
                            shift_q <= {rx_s, shift_q[DATA_W-1:1]};
                            idx_q   <= idx_q + 1'b1;
                            if (idx_q == IW'(DATA_W - 1)) begin
                                addr_o  <= 1'b0;
                                state_q <= mp_fmt ? ST_ADDR : ST_STOP;
                            end
                        end
                    end
                    ST_ADDR: begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CW'(LAST)) begin
                            addr_o  <= rx_s;
                            state_q <= ST_STOP;
                        end
                    end
                    ST_STOP: begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CW'(LAST)) begin
                            stop_ok_o <= rx_s;
                            done_o    <= 1'b1;
                            state_q   <= ST_IDLE;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mpr_status.sv
// Acceptance filter and status flags. It decides whether a finished
// character may reach the status, then updates the data, data-ready,
// framing and overrun flags.
// Assumes: done_i is a one-cycle pulse and its data fields are stable with it.
module mpr_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              addr_i,
    input  logic              stop_ok_i,
    input  logic              mp_fmt,
    input  logic              wake,
    input  logic              data_rd,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              err_ovr,
    output logic              err_frm,
    output logic              addr_last
);
    logic take;
    logic full_eff;

    // A character passes unless the armed filter sees address bit 0.
    assign take     = done_i && (!mp_fmt || !wake || addr_i);
    assign full_eff = rx_full && !data_rd;

    // Flag and data update; a new event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data   <= '0;
            rx_full   <= 1'b0;
            err_ovr   <= 1'b0;
            err_frm   <= 1'b0;
            addr_last <= 1'b0;
        end else begin
            if (data_rd) rx_full <= 1'b0;
            if (err_clr) begin
                err_ovr <= 1'b0;
                err_frm <= 1'b0;
            end
            if (take) begin
                if (full_eff) begin
                    err_ovr <= 1'b1;
                end else begin
                    rx_data   <= data_i;
                    rx_full   <= 1'b1;
                    addr_last <= addr_i && mp_fmt;
                end
                if (!stop_ok_i) err_frm <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mpr_ctrl.sv
// Control register. Holds the enables, the request-to-send level and the
// mode field. Bit 3 reads the last accepted address bit; a write with
// bit 3 = 0 requests an error-flag clear.
// Assumes: reg_wr is a single-cycle strobe.
module mpr_ctrl (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [7:0]           reg_wdata,
    input  logic                 addr_last,
    output mpr_pkg::ctrl_t       ctrl_o,
    output logic                 err_clr_o,
    output logic [7:0]           rdata_o
);
    import mpr_pkg::*;

    assign err_clr_o = reg_wr && !reg_wdata[3];
    assign rdata_o   = {ctrl_o.wake, ctrl_o.rx_en, ctrl_o.tx_en, ctrl_o.rts,
                        addr_last, ctrl_o.mode};

    // Register write; request-to-send resets high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o <= '{wake: 1'b0, rx_en: 1'b0, tx_en: 1'b0, rts: 1'b1, mode: 3'b000};
        end else if (reg_wr) begin
            ctrl_o <= '{wake: reg_wdata[7], rx_en: reg_wdata[6], tx_en: reg_wdata[5],
                        rts: reg_wdata[4], mode: reg_wdata[2:0]};
        end
    end
endmodule

// File: rtl/mp_uart_rx.sv
// Top of the multidrop serial receiver. It connects the control register,
// the bit engine and the acceptance and status logic.
// Assumes: an 8-bit character with no parity.
module mp_uart_rx #(
    parameter int DATA_W = 8,
    parameter int OS     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_i,
    input  logic              mp_fmt,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    input  logic              data_rd,
    output logic [7:0]        ctrl_rdata,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              err_ovr,
    output logic              err_frm,
    output logic              rts_o
);
    import mpr_pkg::*;

    ctrl_t             ctrl;
    logic              err_clr;
    logic              addr_last;
    logic              done;
    logic [DATA_W-1:0] char_data;
    logic              char_addr;
    logic              char_stop_ok;
    logic              busy;

    assign rts_o = ctrl.rts;

    mpr_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .addr_last(addr_last), .ctrl_o(ctrl), .err_clr_o(err_clr),
        .rdata_o(ctrl_rdata)
    );

    mpr_bit_engine #(.DATA_W(DATA_W), .OS(OS)) u_engine (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .enable(ctrl.rx_en),
        .mp_fmt(mp_fmt), .rx_i(rx_i), .done_o(done), .data_o(char_data),
        .addr_o(char_addr), .stop_ok_o(char_stop_ok), .busy_o(busy)
    );

    mpr_status #(.DATA_W(DATA_W)) u_status (
        .clk(clk), .rst_n(rst_n), .done_i(done), .data_i(char_data),
        .addr_i(char_addr), .stop_ok_i(char_stop_ok), .mp_fmt(mp_fmt),
        .wake(ctrl.wake), .data_rd(data_rd), .err_clr(err_clr),
        .rx_data(rx_data), .rx_full(rx_full), .err_ovr(err_ovr),
        .err_frm(err_frm), .addr_last(addr_last)
    );
endmodule

// File: rtl/mp_uart_rx_chk.sv
// Property checker for mp_uart_rx, attached with bind.
module mp_uart_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              data_rd,
    input logic              reg_wr,
    input logic              mp_fmt,
    input logic              wake,
    input logic              rx_en,
    input logic              done,
    input logic              char_addr,
    input logic              busy,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_full,
    input logic              err_ovr,
    input logic              err_frm
);
    // R9
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !done) |=> !rx_full);

    // R8
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !data_rd) |=> $stable(rx_data));

    // R8
    ovr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_ovr) |-> $past(done));

    // R3
    filter_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mp_fmt && wake && !char_addr && !reg_wr && !data_rd)
        |=> $stable({rx_full, err_ovr, err_frm, rx_data}));

    // R11
    idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !busy);
endmodule

bind mp_uart_rx mp_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .data_rd(data_rd), .reg_wr(reg_wr),
    .mp_fmt(mp_fmt), .wake(ctrl.wake), .rx_en(ctrl.rx_en), .done(done),
    .char_addr(char_addr), .busy(busy), .rx_data(rx_data),
    .rx_full(rx_full), .err_ovr(err_ovr), .err_frm(err_frm)
);

// File: tb/mp_uart_rx_bench.sv
// Self-checking bench for mp_uart_rx: a vector table, then directed tests.
module mp_uart_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_i = 1'b1;
    logic       mp_fmt = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       data_rd = 1'b0;
    logic [7:0] ctrl_rdata;
    logic [7:0] rx_data;
    logic       rx_full, err_ovr, err_frm, rts_o;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mp_uart_rx u_mp_uart_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(1'b1), .rx_i(rx_i), .mp_fmt(mp_fmt),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .data_rd(data_rd),
        .ctrl_rdata(ctrl_rdata), .rx_data(rx_data), .rx_full(rx_full),
        .err_ovr(err_ovr), .err_frm(err_frm), .rts_o(rts_o)
    );

    // Vector fields: [12] format, [11] filter, [10] address bit,
    // [9] stop good, [8] expect accept, [7:0] byte.
    localparam logic [12:0] VEC [8] = '{
        {5'b00011, 8'hA5},
        {5'b01011, 8'h3C},
        {5'b11010, 8'h5A},
        {5'b11111, 8'hC3},
        {5'b10011, 8'h81},
        {5'b11000, 8'h77},
        {5'b11101, 8'hE1},
        {5'b00001, 8'h0F}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        rx_i = b;
        repeat (16) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] d, input logic fmt, input logic addr,
                             input logic stop);
        @(negedge clk);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        if (fmt) send_bit(addr);
        send_bit(stop);
        rx_i = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [7:0] prev;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ctrl", ctrl_rdata, 8'h10);
        check("R1 flags", {5'b0, rx_full, err_ovr, err_frm}, 8'h00);
        check("R1 rts", {7'b0, rts_o}, 8'h01);

        prev = 8'h00;
        for (int v = 0; v < 8; v++) begin
            logic fmt, wk, ad, st, acc;
            logic [7:0] b;
            {fmt, wk, ad, st, acc, b} = VEC[v];
            mp_fmt = fmt;
            wr_ctrl({wk, 7'b1011000});
            send_char(b, fmt, ad, st);
            // R2 R3 R4 R5 R6 data-ready follows the filter outcome
            check($sformatf("R3/R4/R5/R6 full v%0d", v), {7'b0, rx_full}, {7'b0, acc});
            // R2 R3 data delivered or kept
            check($sformatf("R2/R3 data v%0d", v), rx_data, acc ? b : prev);
            // R7 R3 framing only on accepted bad stop
            check($sformatf("R7/R3 frm v%0d", v), {7'b0, err_frm}, {7'b0, acc && !st});
            if (acc && fmt) check($sformatf("R4/R5 addr bit v%0d", v),
                                  {7'b0, ctrl_rdata[3]}, {7'b0, ad});
            if (acc) prev = b;
            if (rx_full) pulse_rd();
            wr_ctrl({wk, 7'b1010000});
        end

        // R9 read clears data-ready
        mp_fmt = 1'b0;
        wr_ctrl(8'h58);
        send_char(8'h42, 1'b0, 1'b0, 1'b1);
        check("R9 full before read", {7'b0, rx_full}, 8'h01);
        pulse_rd();
        check("R9 full after read", {7'b0, rx_full}, 8'h00);

        // R8 overrun keeps older data
        send_char(8'h11, 1'b0, 1'b0, 1'b1);
        send_char(8'h22, 1'b0, 1'b0, 1'b1);
        check("R8 ovr", {7'b0, err_ovr}, 8'h01);
        check("R8 data kept", rx_data, 8'h11);

        // R10 bit 3 = 1 keeps errors, bit 3 = 0 clears them
        wr_ctrl(8'h58);
        check("R10 no clear", {7'b0, err_ovr}, 8'h01);
        wr_ctrl(8'h50);
        check("R10 clear", {6'b0, err_ovr, err_frm}, 8'h00);
        pulse_rd();

        // R11 receiver disabled ignores line
        wr_ctrl(8'h18);
        send_char(8'h99, 1'b0, 1'b0, 1'b0);
        check("R11 disabled", {6'b0, rx_full, err_frm}, 8'h00);
        check("R11 data", rx_data, 8'h11);

        // R12 glitch shorter than half a bit
        wr_ctrl(8'h58);
        @(negedge clk); rx_i = 1'b0;
        repeat (4) @(negedge clk);
        rx_i = 1'b1;
        repeat (200) @(negedge clk);
        check("R12 glitch", {6'b0, rx_full, err_frm}, 8'h00);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule